// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel that executes a chain of command descriptors stored in memory. Software loads the address of the first descriptor into a next-command register and then adds a count to a semaphore. While the semaphore is non-zero and the channel is idle, it fetches a descriptor, issues that descriptor's peripheral programming words to a register port, and moves the stated byte count. Data moves in one of two directions: from a memory buffer out to the peripheral, or from the peripheral into a memory buffer. The channel then either follows the descriptor's next pointer or stops.

A descriptor occupies consecutive 32-bit words. The first word is the next pointer. The second word holds the control field in its low half and the byte count in its high half. The third word is the buffer address, and up to fifteen programming words follow. Data moves one 32-bit word per beat, so a byte count of N needs ceil(N/4) beats. Memory is reached through a simple word port. A request is complete in any cycle where the acknowledge is high, and read data is valid in that cycle. The channel also has a freeze input, a channel reset input, a completion pulse and a bus-error pulse.

Top module: `dma_chain_seq`

## Requirements
- R1: After a start, the header words are read in this order: next pointer at D, {byte count[31:16], control[15:0]} at D+4, and buffer address at D+8.
- R2: A write on the semaphore port adds its value to the 8-bit semaphore, which saturates at 255. An idle channel with a non-zero semaphore starts fetching at the next-command register. An idle channel with a zero semaphore issues no request.
- R3: Control bits [15:12] give the number of programming words. Word k is read from D+12+4k and is issued as a single-cycle strobe with index k. Strobes go out in ascending k, and all of them precede any data beat of the same descriptor.
- R4: The command is in control bits [1:0]. Value 0 moves no data. Value 2 reads ceil(count/4) words upward from the buffer and presents each one to the peripheral. Value 1 accepts ceil(count/4) words from the peripheral and writes them upward from the buffer.
- R5: Command 3, or a byte count above 0xFF00, produces a bus-error pulse with no data beat and no completion. A count of exactly 0xFF00 is accepted.
- R6: With control bit 2 (chain) set, the next descriptor is fetched from the next pointer without software action. A chain that loops back on itself runs cyclically. At every completion the next pointer is copied into the next-command register.
- R7: On completion, a descriptor with control bit 6 decrements the semaphore. The channel continues if the chain bit is set or if the semaphore is still non-zero after that decrement. Otherwise it goes idle.
- R8: With control bit 7 set, completion waits for a peripheral end strobe that arrives after the last data beat.
- R9: On completion of a descriptor with control bit 3 set, done_irq_o is high for exactly one cycle, after the descriptor's last strobe or beat.
- R10: A memory error on an acknowledged request, or a peripheral error during a data or end-wait phase, gives a one-cycle bus-error pulse, returns the channel to idle and clears the semaphore.
- R11: While freeze_i is high, no memory request, programming strobe, data handshake or completion occurs. On release the channel resumes from the same position.
- R12: A channel reset pulse aborts the current descriptor, returns the channel to idle and clears the semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Write strobe for the next-command register |
| cmd_addr_i | input | 32 | Address of the first descriptor |
| sema_wr_i | input | 1 | Semaphore add strobe |
| sema_add_i | input | 8 | Value added to the semaphore |
| freeze_i | input | 1 | Suspend the channel |
| chan_reset_i | input | 1 | Abort the channel and clear the semaphore |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_err_i | input | 1 | Completing request failed |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| pio_wr_o | output | 1 | Programming word strobe |
| pio_idx_o | output | 4 | Programming word index |
| pio_data_o | output | 32 | Programming word value |
| tx_valid_o | output | 1 | Data word to the peripheral is valid |
| tx_ready_i | input | 1 | Peripheral takes the word |
| tx_data_o | output | 32 | Data word to the peripheral |
| rx_valid_i | input | 1 | Peripheral offers a word |
| rx_ready_o | output | 1 | Channel takes the word |
| rx_data_i | input | 32 | Data word from the peripheral |
| per_end_i | input | 1 | Peripheral end strobe |
| per_err_i | input | 1 | Peripheral error |
| done_irq_o | output | 1 | Completion pulse |
| bus_err_o | output | 1 | Bus-error pulse |

## Verification
The assertions check properties that must hold on every cycle. No data beat occurs before all programming strobes have gone out. No beat occurs for an unsupported command or an oversized count. Freeze keeps the sequencer state unchanged and the ports quiet. The completion pulse lasts exactly one cycle. After an error or a channel reset, no further traffic appears. Only the bench scenarios can show the rest, because it depends on memory content and descriptor order: the data values and addresses that pass through, the order of header reads, semaphore-driven continuation across unchained descriptors, cyclic chains, end-strobe waiting, and the accepted 0xFF00 boundary.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_TO_MEM   = 2'd1,
    CMD_FROM_MEM = 2'd2,
    CMD_SENSE    = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [3:0] pio_n;
    logic [1:0] rsvd;
    logic       flush;
    logic       halt_term;
    logic       wait_end;
    logic       dec_sema;
    logic [1:0] spare;
    logic       irq;
    logic       chain;
    cmd_e       cmd;
  } ctrl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_PIO_RD, ST_PIO_WR, ST_MEM_RD,
    ST_TX, ST_RX, ST_MEM_WR, ST_WAIT_END, ST_DONE
  } state_e;

endpackage

// File: rtl/dma_sema_cnt.sv
module dma_sema_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         add_i,
  input  logic [W-1:0] add_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q, sat, nxt;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, count_q} + {1'b0, (add_i ? add_val_i : '0)};
    sat = sum[W] ? '1 : sum[W-1:0];
    nxt = (dec_i && sat != '0) ? sat - W'(1) : sat;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      count_q <= '0;
    else if (clear_i) count_q <= '0;
    else              count_q <= nxt;

  assign count_o = count_q;

  assert_sema_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !add_i && !clear_i && count_q != '0) |=> count_q == $past(count_q) - W'(1));
  assert_sema_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !add_i && !clear_i) |=> $stable(count_q));
  assert_sema_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_q == '0);
endmodule

// File: rtl/dma_desc_check.sv
module dma_desc_check import dma_seq_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int WB_LOG    = 2,
  parameter int MAX_BYTES = 'hFF00
) (
  input  ctrl_t              ctrl_i,
  input  logic [CNT_W-1:0]   bytes_i,
  output logic [CNT_W-1:0]   words_o,
  output logic               bad_o
);
  localparam logic [CNT_W:0] ROUND = (CNT_W+1)'((1 << WB_LOG) - 1);
  logic [CNT_W:0] rnd;

  always_comb begin
    rnd     = {1'b0, bytes_i} + ROUND;
    words_o = CNT_W'(rnd >> WB_LOG);
    bad_o   = (ctrl_i.cmd == CMD_SENSE) || (bytes_i > CNT_W'(MAX_BYTES));
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq import dma_seq_pkg::*; #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int SEMA_W    = 8,
  parameter int MAX_BYTES = 'hFF00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [AW-1:0]     cmd_addr_i,
  input  logic              sema_wr_i,
  input  logic [SEMA_W-1:0] sema_add_i,
  input  logic              freeze_i,
  input  logic              chan_reset_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              pio_wr_o,
  output logic [3:0]        pio_idx_o,
  output logic [DW-1:0]     pio_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DW-1:0]     tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              per_end_i,
  input  logic              per_err_i,
  output logic              done_irq_o,
  output logic              bus_err_o
);
  localparam int WB        = DW / 8;
  localparam int WB_LOG    = $clog2(WB);
  localparam int CNT_W     = DW / 2;
  localparam int HDR_WORDS = 3;

  state_e            state_q;
  logic [AW-1:0]     cmd_ptr_q, cur_q, nxt_q, buf_q;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q, word_q, n_words;
  logic [1:0]        hdr_idx_q;
  logic [4:0]        pio_k_q;
  logic [DW-1:0]     data_q;
  logic              err_q;
  logic [SEMA_W-1:0] sema_cnt;

  logic   active, mem_hit, fmt_bad, fmt_fault, mem_fault, per_fault, fault;
  logic   last_word, sema_left, sema_dec, in_data;
  state_e end_st, after_pio;

  dma_desc_check #(.CNT_W(CNT_W), .WB_LOG(WB_LOG), .MAX_BYTES(MAX_BYTES)) i_check (
    .ctrl_i (ctrl_q), .bytes_i (cnt_q), .words_o (n_words), .bad_o (fmt_bad)
  );

  dma_sema_cnt #(.W(SEMA_W)) i_sema (
    .clk_i, .rst_ni,
    .clear_i   (chan_reset_i || fault),
    .add_i     (sema_wr_i),
    .add_val_i (sema_add_i),
    .dec_i     (sema_dec),
    .count_o   (sema_cnt)
  );

  always_comb begin
    active     = !freeze_i;
    mem_req_o  = active && (state_q inside {ST_HDR, ST_PIO_RD, ST_MEM_RD, ST_MEM_WR});
    mem_we_o   = (state_q == ST_MEM_WR);
    mem_wdata_o = data_q;
    unique case (state_q)
      ST_HDR:              mem_addr_o = cur_q + (AW'(hdr_idx_q) << WB_LOG);
      ST_PIO_RD:           mem_addr_o = cur_q + ((AW'(pio_k_q) + AW'(HDR_WORDS)) << WB_LOG);
      ST_MEM_RD, ST_MEM_WR: mem_addr_o = buf_q + (AW'(word_q) << WB_LOG);
      default:             mem_addr_o = cur_q;
    endcase
    mem_hit    = mem_req_o && mem_ack_i;
    mem_fault  = mem_hit && mem_err_i;
    fmt_fault  = active && state_q == ST_HDR && mem_hit && hdr_idx_q == 2'd2 && fmt_bad;
    per_fault  = active && per_err_i && (state_q inside {ST_TX, ST_RX, ST_WAIT_END});
    fault      = mem_fault || fmt_fault || per_fault;

    pio_wr_o   = active && state_q == ST_PIO_WR;
    pio_idx_o  = pio_k_q[3:0];
    pio_data_o = data_q;
    tx_valid_o = active && state_q == ST_TX;
    tx_data_o  = data_q;
    rx_ready_o = active && state_q == ST_RX;
    done_irq_o = active && state_q == ST_DONE && ctrl_q.irq;
    bus_err_o  = err_q;

    sema_dec   = active && state_q == ST_DONE && ctrl_q.dec_sema;
    sema_left  = sema_cnt > SEMA_W'(ctrl_q.dec_sema);
    last_word  = (word_q + CNT_W'(1)) >= n_words;
    end_st     = ctrl_q.wait_end ? ST_WAIT_END : ST_DONE;
    unique case (ctrl_q.cmd)
      CMD_FROM_MEM: after_pio = (n_words != '0) ? ST_MEM_RD : end_st;
      CMD_TO_MEM:   after_pio = (n_words != '0) ? ST_RX : end_st;
      default:      after_pio = end_st;
    endcase
    in_data    = tx_valid_o || rx_ready_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;   cmd_ptr_q <= '0; cur_q  <= '0; nxt_q  <= '0;
      buf_q   <= '0;        ctrl_q    <= '0; cnt_q  <= '0; word_q <= '0;
      hdr_idx_q <= '0;      pio_k_q   <= '0; data_q <= '0; err_q  <= 1'b0;
    end else if (chan_reset_i) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      if (cmd_wr_i) cmd_ptr_q <= cmd_addr_i;
    end else begin
      err_q <= 1'b0;
      if (cmd_wr_i) cmd_ptr_q <= cmd_addr_i;
      if (fault) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b1;
      end else if (active) begin
        unique case (state_q)
          ST_IDLE: if (sema_cnt != '0) begin
            cur_q     <= cmd_ptr_q;
            hdr_idx_q <= '0;
            state_q   <= ST_HDR;
          end
          ST_HDR: if (mem_hit) begin
            hdr_idx_q <= hdr_idx_q + 2'd1;
            unique case (hdr_idx_q)
              2'd0:    nxt_q <= mem_rdata_i;
              2'd1:    begin ctrl_q <= ctrl_t'(mem_rdata_i[CNT_W-1:0]); cnt_q <= mem_rdata_i[DW-1:CNT_W]; end
              default: begin
                buf_q   <= mem_rdata_i;
                pio_k_q <= '0;
                word_q  <= '0;
                state_q <= (ctrl_q.pio_n != '0) ? ST_PIO_RD : after_pio;
              end
            endcase
          end
          ST_PIO_RD: if (mem_hit) begin
            data_q  <= mem_rdata_i;
            state_q <= ST_PIO_WR;
          end
          ST_PIO_WR: begin
            pio_k_q <= pio_k_q + 5'd1;
            state_q <= ((pio_k_q + 5'd1) < {1'b0, ctrl_q.pio_n}) ? ST_PIO_RD : after_pio;
          end
          ST_MEM_RD: if (mem_hit) begin
            data_q  <= mem_rdata_i;
            state_q <= ST_TX;
          end
          ST_TX: if (tx_ready_i) begin
            word_q  <= word_q + CNT_W'(1);
            state_q <= last_word ? end_st : ST_MEM_RD;
          end
          ST_RX: if (rx_valid_i) begin
            data_q  <= rx_data_i;
            state_q <= ST_MEM_WR;
          end
          ST_MEM_WR: if (mem_hit) begin
            word_q  <= word_q + CNT_W'(1);
            state_q <= last_word ? end_st : ST_RX;
          end
          ST_WAIT_END: if (per_end_i) state_q <= ST_DONE;
          ST_DONE: begin
            cmd_ptr_q <= nxt_q;
            if (ctrl_q.chain || sema_left) begin
              cur_q     <= nxt_q;
              hdr_idx_q <= '0;
              state_q   <= ST_HDR;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_pio_before_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data |-> pio_k_q == {1'b0, ctrl_q.pio_n});
  assert_no_bad_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data |-> (cnt_q <= CNT_W'(MAX_BYTES) && ctrl_q.cmd != CMD_SENSE));
  assert_beat_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data |-> word_q < n_words);
  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
  assert_err_halts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !(mem_req_o || pio_wr_o || in_data || done_irq_o));
  assert_freeze_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |-> !(mem_req_o || pio_wr_o || in_data || done_irq_o));
  assert_freeze_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(freeze_i) && !$past(chan_reset_i)) |-> $stable(state_q));
  assert_reset_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_reset_i |=> !(mem_req_o || pio_wr_o || in_data || done_irq_o));
endmodule

// File: tb/test_dma_chain_seq.sv
`timescale 1ns/1ps
module test_dma_chain_seq;
  localparam real HALF = 2.5;
  localparam logic [15:0] F_CHAIN = 16'h0004, F_IRQ = 16'h0008,
                          F_DEC = 16'h0040, F_WAIT = 16'h0080;

  typedef struct packed { logic [3:0] tag; logic [31:0] a; logic [31:0] d; } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, sema_wr = 0, freeze = 0, chan_rst = 0, per_end = 0, per_err = 0;
  logic tx_rdy = 1'b1;
  logic [31:0] cmd_addr = '0, err_addr = 32'hFFFF_FFFF;
  logic [7:0]  sema_add = '0, rx_seq = '0;
  logic mem_req, mem_we, mem_ack, mem_err, pio_wr, tx_valid, rx_ready, done_irq, bus_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pio_data, tx_data, rx_data;
  logic [3:0]  pio_idx;
  logic [31:0] mem [0:255];

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0, act_cnt = 0, irq_cnt = 0, berr_cnt = 0, exp_rx = 0, rd_n = 4;
  logic [31:0] rd_a [0:3];

  always #(HALF) clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_err   = mem_req && (mem_addr == err_addr);
  assign mem_rdata = mem[mem_addr[9:2]];
  assign rx_data   = 32'hA500_0000 | {24'h0, rx_seq};

  dma_chain_seq i_dma_chain_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_addr_i(cmd_addr),
    .sema_wr_i(sema_wr), .sema_add_i(sema_add), .freeze_i(freeze), .chan_reset_i(chan_rst),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .pio_wr_o(pio_wr), .pio_idx_o(pio_idx), .pio_data_o(pio_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_rdy), .tx_data_o(tx_data),
    .rx_valid_i(1'b1), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .per_end_i(per_end), .per_err_i(per_err), .done_irq_o(done_irq), .bus_err_o(bus_err)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
    if (rx_ready) rx_seq <= rx_seq + 8'd1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) if (rst_n) begin
    item_t got, e;
    logic  got_v;
    string rq;
    got_v = 1'b0; got = '0; rq = "R4";
    if (mem_req || pio_wr || tx_valid || rx_ready || done_irq) act_cnt++;
    if (mem_req && !mem_we && rd_n < 4) begin rd_a[rd_n] = mem_addr; rd_n++; end
    if (bus_err) berr_cnt++;
    if (pio_wr)                         begin got = '{4'd1, 32'(pio_idx), pio_data}; got_v = 1; rq = "R3"; end
    if (tx_valid && tx_rdy)             begin got = '{4'd2, 32'h0, tx_data};         got_v = 1; end
    if (mem_req && mem_we && !mem_err)  begin got = '{4'd3, mem_addr, mem_wdata};    got_v = 1; end
    if (done_irq)                       begin got = '{4'd4, 32'h0, 32'h0}; got_v = 1; rq = "R9"; irq_cnt++; end
    if (got_v) begin
      if (exp_q.size() == 0) chk(1'b0, rq, "unexpected item", got, '0);
      else begin
        e = exp_q.pop_front();
        chk(got == e, rq, "scoreboard item", got, e);
      end
    end
  end

  task automatic load_desc(input int a, input logic [31:0] nxt, input logic [1:0] cmd,
                           input logic [15:0] flags, input int npio, input logic [15:0] bytes,
                           input logic [31:0] bufa);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = {bytes, 4'(npio), flags[11:2], cmd};
    mem[a/4 + 2] = bufa;
    for (int k = 0; k < npio; k++) mem[a/4 + 3 + k] = 32'hC000_0000 + 32'(a * 16 + k);
  endtask

  task automatic exp_desc(input int a);
    logic [31:0] w1, bufa;
    int npio, nw;
    w1 = mem[a/4 + 1]; bufa = mem[a/4 + 2];
    npio = int'(w1[15:12]); nw = (int'(w1[31:16]) + 3) / 4;
    for (int k = 0; k < npio; k++) exp_q.push_back('{4'd1, 32'(k), mem[a/4 + 3 + k]});
    if (w1[1:0] == 2'd2)
      for (int w = 0; w < nw; w++) exp_q.push_back('{4'd2, 32'h0, mem[(int'(bufa[9:2]) + w) % 256]});
    if (w1[1:0] == 2'd1)
      for (int w = 0; w < nw; w++) begin
        exp_q.push_back('{4'd3, bufa + 32'(4 * w), 32'hA500_0000 | 32'(exp_rx % 256)});
        exp_rx++;
      end
    if (w1[3]) exp_q.push_back('{4'd4, 32'h0, 32'h0});
  endtask

  task automatic set_ptr(input logic [31:0] a);
    @(posedge clk); #1 cmd_wr = 1; cmd_addr = a;
    @(posedge clk); #1 cmd_wr = 0;
  endtask

  task automatic add_sema(input logic [7:0] v);
    @(posedge clk); #1 sema_wr = 1; sema_add = v;
    @(posedge clk); #1 sema_wr = 0;
  endtask

  task automatic drain(input string req, input int maxc);
    int c = 0;
    while (exp_q.size() != 0 && c < maxc) begin @(posedge clk); c++; end
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, req, "scoreboard drained", 68'(exp_q.size()), 68'd0);
  endtask

  task automatic quiet(input string req, input int n);
    int a0 = act_cnt;
    repeat (n) @(posedge clk);
    chk(act_cnt == a0, req, "channel quiet", 68'(act_cnt - a0), 68'd0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    chk(1'b0, "WDOG", "watchdog expired", '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b0, i0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i);
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !pio_wr && !tx_valid && !rx_ready, "R2", "reset outputs idle",
        {64'h0, mem_req, pio_wr, tx_valid, rx_ready}, '0);
    chk(!done_irq && !bus_err, "R9", "reset pulses low", {66'h0, done_irq, bus_err}, '0);
    quiet("R2", 10);

    // R1 R3 R7: programming-only descriptor, semaphore 1, stops afterwards
    load_desc(32'h40, 32'h80, 2'd0, F_IRQ | F_DEC, 3, 16'd0, 32'h0);
    exp_desc(32'h40);
    set_ptr(32'h40);
    rd_n = 0;
    add_sema(8'd1);
    drain("R3", 200);
    chk(rd_a[0] == 32'h40 && rd_a[1] == 32'h44 && rd_a[2] == 32'h48, "R1", "header read order",
        {4'h0, rd_a[0][15:0], rd_a[1][15:0], rd_a[2][15:0], rd_a[3][15:0]}, 68'h0_0040_0044_0048_004C);
    chk(rd_a[3] == 32'h4C, "R3", "first programming word address", 68'(rd_a[3]), 68'h4C);
    quiet("R7", 20);

    // R4 R6: chained read-out then write-in, started from saved next pointer
    load_desc(32'h80, 32'hC0, 2'd2, F_CHAIN, 2, 16'd10, 32'h200);
    load_desc(32'hC0, 32'h40, 2'd1, F_IRQ | F_DEC, 0, 16'd8, 32'h300);
    exp_desc(32'h80); exp_desc(32'hC0);
    add_sema(8'd1);
    drain("R6", 400);
    chk(mem[32'h300 / 4] == 32'hA500_0000 && mem[32'h304 / 4] == 32'hA500_0001, "R4",
        "words stored from peripheral", {4'h0, mem[32'h300 / 4], mem[32'h304 / 4]},
        {4'h0, 32'hA500_0000, 32'hA500_0001});
    quiet("R7", 20);

    // R8: end strobe gates completion
    load_desc(32'h100, 32'h40, 2'd0, F_IRQ | F_DEC | F_WAIT, 1, 16'd0, 32'h0);
    exp_desc(32'h100);
    set_ptr(32'h100);
    i0 = irq_cnt;
    add_sema(8'd1);
    while (exp_q.size() > 1) @(posedge clk);
    repeat (15) @(posedge clk);
    chk(irq_cnt == i0, "R8", "no completion before end strobe", 68'(irq_cnt - i0), 68'd0);
    #1 per_end = 1; @(posedge clk); #1 per_end = 0;
    drain("R8", 50);

    // R5: oversized count and unsupported command, then the exact limit
    b0 = berr_cnt;
    load_desc(32'h140, 32'h40, 2'd2, F_IRQ | F_DEC, 0, 16'hFF04, 32'h200);
    set_ptr(32'h140); add_sema(8'd1);
    repeat (20) @(posedge clk);
    chk(berr_cnt == b0 + 1, "R5", "oversized count faults", 68'(berr_cnt - b0), 68'd1);
    load_desc(32'h180, 32'h40, 2'd3, F_IRQ | F_DEC, 0, 16'd4, 32'h200);
    set_ptr(32'h180); add_sema(8'd1);
    repeat (20) @(posedge clk);
    chk(berr_cnt == b0 + 2, "R5", "sense command faults", 68'(berr_cnt - b0), 68'd2);
    load_desc(32'h1C0, 32'h40, 2'd2, F_IRQ | F_DEC, 0, 16'hFF00, 32'h200);
    exp_desc(32'h1C0);
    set_ptr(32'h1C0); add_sema(8'd1);
    drain("R5", 40000);
    chk(berr_cnt == b0 + 2, "R5", "limit count accepted", 68'(berr_cnt - b0), 68'd2);

    // R10: memory error mid-transfer clears semaphore
    b0 = berr_cnt;
    load_desc(32'h40, 32'h80, 2'd2, F_IRQ | F_DEC, 0, 16'd8, 32'h240);
    exp_q.push_back('{4'd2, 32'h0, mem[32'h240 / 4]});
    err_addr = 32'h244;
    set_ptr(32'h40); add_sema(8'd2);
    drain("R10", 100);
    chk(berr_cnt == b0 + 1, "R10", "memory error pulse", 68'(berr_cnt - b0), 68'd1);
    quiet("R10", 20);
    err_addr = 32'hFFFF_FFFF;

    // R10: peripheral error during transmit
    b0 = berr_cnt;
    load_desc(32'h40, 32'h80, 2'd2, F_IRQ | F_DEC, 0, 16'd8, 32'h240);
    tx_rdy = 0;
    set_ptr(32'h40); add_sema(8'd1);
    repeat (8) @(posedge clk);
    #1 per_err = 1; @(posedge clk); #1 per_err = 0; tx_rdy = 1;
    repeat (3) @(posedge clk);
    chk(berr_cnt == b0 + 1, "R10", "peripheral error pulse", 68'(berr_cnt - b0), 68'd1);
    quiet("R10", 20);

    // R11: freeze mid-descriptor, resume without loss
    load_desc(32'h80, 32'h40, 2'd2, F_IRQ | F_DEC, 1, 16'd16, 32'h280);
    exp_desc(32'h80);
    set_ptr(32'h80); add_sema(8'd1);
    repeat (6) @(posedge clk);
    #1 freeze = 1;
    quiet("R11", 10);
    #1 freeze = 0;
    drain("R11", 200);

    // R6 R12: cyclic ring, then channel reset
    load_desc(32'hC0, 32'h100, 2'd0, F_CHAIN | F_IRQ, 1, 16'd0, 32'h0);
    load_desc(32'h100, 32'hC0, 2'd0, F_CHAIN | F_IRQ, 1, 16'd0, 32'h0);
    for (int r = 0; r < 3; r++) begin exp_desc(32'hC0); exp_desc(32'h100); end
    set_ptr(32'hC0); add_sema(8'd1);
    while (exp_q.size() != 0) @(posedge clk);
    #1 chan_rst = 1; @(posedge clk); #1 chan_rst = 0;
    chk(irq_cnt > 0, "R6", "ring completions seen", 68'(irq_cnt), 68'd1);
    quiet("R12", 30);

    // R2 R7: two unchained descriptors driven by semaphore count
    load_desc(32'h140, 32'h180, 2'd0, F_IRQ | F_DEC, 1, 16'd0, 32'h0);
    load_desc(32'h180, 32'h40, 2'd0, F_IRQ | F_DEC, 2, 16'd0, 32'h0);
    exp_desc(32'h140); exp_desc(32'h180);
    set_ptr(32'h140);
    add_sema(8'd1); add_sema(8'd1);
    drain("R7", 200);
    quiet("R7", 20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule